// File: doc/BRIEF.md
# Multi-channel one-shot enable gate

This block conditions five control-enable lines that a slow controller drives toward a synchronous DRAM. The controller runs on a clock derived from the fast memory clock, so a level it holds stays valid for many fast cycles. The enables it produces therefore have to be reshaped before they reach the chip-select path. The block samples every enable on the fast clock. A single mode input, shared by all lanes, then selects one of two behaviours. In pass-through mode the sampled level is forwarded unchanged, which suits free-running sequences. In pulse mode only a rising edge of the sampled level is forwarded, as an assertion exactly one fast cycle long, so each command reaches the memory once.

The block also divides the fast clock by eight to produce the controller's clock. All outputs drive in one direction only. The block gates enable lines and never drives the bidirectional select lines themselves. The lane index fixes the channel role: lane 0 is chip select 0, lane 1 is the chip-select-1 read enable, lane 2 is the chip-select-1 write enable, lane 3 is the data mask and lane 4 is the address/command mask.

Top module: `oneshot_gate_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, all enable outputs go low and `slow_clk` goes low after that edge. The divider count restarts from zero.
- R2: `slow_clk` is the fast clock divided by 8. After the k-th rising edge with `rst` low (k = 1, 2, ...), `slow_clk` is 1 exactly when (k mod 8) >= 4.
- R3: With `mode_oneshot` = 1, output bit i after edge t is 1 only if `en_in[i]` was 1 at edge t-1 and 0 at edge t-2.
- R4: With `mode_oneshot` = 0, output bit i after edge t equals `en_in[i]` as sampled at edge t-1, for as long as the input is held.
- R5: In pulse mode, an input held high for any number of cycles produces exactly one single-cycle pulse. A new pulse appears only after the input has been low for at least one sampling edge.
- R6: The mode is sampled on the same edge as the enables. Every input change reaches the output after exactly two rising edges, in both modes and on every lane.
- R7: Lanes are independent. Bit i of `en_out` depends only on bit i of `en_in` and on the shared mode, with lane 0 = chip select 0, lane 1 = select 1 read, lane 2 = select 1 write, lane 3 = data mask, lane 4 = address/command mask.
- R8: Switching from pass-through to pulse mode while an input is already held high produces no pulse on that lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast memory clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_oneshot | input | 1 | 1 = pulse mode, 0 = pass-through, shared by all lanes |
| en_in | input | 5 | Raw enables from the controller, one bit per lane |
| en_out | output | 5 | Gated enables toward the chip-select path |
| slow_clk | output | 1 | Fast clock divided by 8 for the controller |

## Verification
The bench builds the block with its default parameters: five lanes and a three-bit divider. With these values a full slow-clock period lasts only eight fast cycles, so two complete divider periods fit into a short directed window. The five-bit lane vector is small enough that the table can write out mixed patterns across every lane. These patterns cover rising edges, held levels, simultaneous edges on neighbouring lanes and a mode switch under a held input. The long-hold test keeps the input high far beyond one slow period, which shows that a held level yields a single pulse.

// File: rtl/oneshot_gate_pkg.sv
package oneshot_gate_pkg;

    typedef enum logic {
        GATE_PASS  = 1'b0,
        GATE_PULSE = 1'b1
    } gate_mode_e;

    typedef struct packed {
        logic sample;
        logic prev;
        logic gated;
    } lane_state_t;

endpackage

// File: rtl/oneshot_divider.sv
module oneshot_divider #(
    parameter int DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst,
    output logic slow_clk
);
    typedef struct packed {
        logic [DIV_LOG2-1:0] count;
    } div_state_t;

    div_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.count = state_q.count + 1'b1;
        if (rst) begin
            state_d.count = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign slow_clk = state_q.count[DIV_LOG2-1];
endmodule

// File: rtl/oneshot_lane.sv
module oneshot_lane
    import oneshot_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  gate_mode_e mode_q,
    input  logic       en_raw,
    output logic       en_gated
);
    lane_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.sample = en_raw;
        state_d.prev   = state_q.sample;
        if (mode_q == GATE_PULSE) begin
            state_d.gated = state_q.sample & ~state_q.prev;
        end else begin
            state_d.gated = state_q.sample;
        end
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign en_gated = state_q.gated;
endmodule

// File: rtl/oneshot_gate_top.sv
module oneshot_gate_top
    import oneshot_gate_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int DIV_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_oneshot,
    input  logic [NUM_CH-1:0] en_in,
    output logic [NUM_CH-1:0] en_out,
    output logic              slow_clk
);
    typedef struct packed {
        gate_mode_e mode;
    } ctrl_state_t;

    ctrl_state_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.mode = mode_oneshot ? GATE_PULSE : GATE_PASS;
        if (rst) begin
            ctrl_d.mode = GATE_PASS;
        end
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_lane
        oneshot_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .mode_q   (ctrl_q.mode),
            .en_raw   (en_in[gi]),
            .en_gated (en_out[gi])
        );
    end

    oneshot_divider #(
        .DIV_LOG2 (DIV_LOG2)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .slow_clk (slow_clk)
    );
endmodule

// File: rtl/oneshot_gate_chk.sv
module oneshot_gate_chk #(
    parameter int NUM_CH   = 5,
    parameter int DIV_LOG2 = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_oneshot,
    input logic [NUM_CH-1:0] en_in,
    input logic [NUM_CH-1:0] en_out,
    input logic              slow_clk
);
    logic [2:0]          age_q;
    logic [DIV_LOG2-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q   <= '0;
            phase_q <= '0;
        end else begin
            if (age_q != 3'd7) age_q <= age_q + 3'd1;
            phase_q <= phase_q + 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (en_out == '0 && slow_clk == 1'b0));

    // R2
    divider_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd1) |-> (slow_clk == phase_q[DIV_LOG2-1]));

    // R3
    pulse_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd3 && $past(mode_oneshot, 2))
        |-> (en_out == ($past(en_in, 2) & ~$past(en_in, 3))));

    // R4
    pass_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd2 && !$past(mode_oneshot, 2))
        |-> (en_out == $past(en_in, 2)));

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd4 && $past(mode_oneshot, 2) && $past(mode_oneshot, 3))
        |-> ((en_out & $past(en_out)) == '0));
endmodule

bind oneshot_gate_top oneshot_gate_chk #(
    .NUM_CH   (NUM_CH),
    .DIV_LOG2 (DIV_LOG2)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_oneshot (mode_oneshot),
    .en_in        (en_in),
    .en_out       (en_out),
    .slow_clk     (slow_clk)
);

// File: tb/oneshot_gate_top_test.sv
module oneshot_gate_top_test;
    localparam int NUM_CH = 5;
    localparam int NVEC   = 14;

    // {mode, en_in, expected en_out two edges later}
    localparam logic [10:0] TABLE [0:NVEC-1] = '{
        {1'b1, 5'b00001, 5'b00001},
        {1'b1, 5'b00001, 5'b00000},
        {1'b1, 5'b00011, 5'b00010},
        {1'b1, 5'b00000, 5'b00000},
        {1'b1, 5'b10101, 5'b10101},
        {1'b1, 5'b11111, 5'b01010},
        {1'b0, 5'b11111, 5'b11111},
        {1'b0, 5'b00110, 5'b00110},
        {1'b0, 5'b00110, 5'b00110},
        {1'b1, 5'b00110, 5'b00000},
        {1'b1, 5'b00000, 5'b00000},
        {1'b1, 5'b11111, 5'b11111},
        {1'b1, 5'b00000, 5'b00000},
        {1'b0, 5'b01001, 5'b01001}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode_oneshot = 1'b1;
    logic [NUM_CH-1:0] en_in = '0;
    logic [NUM_CH-1:0] en_out;
    logic              slow_clk;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    oneshot_gate_top uut (
        .clk          (clk),
        .rst          (rst),
        .mode_oneshot (mode_oneshot),
        .en_in        (en_in),
        .en_out       (en_out),
        .slow_clk     (slow_clk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int cnt [NUM_CH];
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs in reset", en_out, 0);
        chk("R1 slow clock in reset", slow_clk, 0);
        rst = 1'b0;

        // R2 divider: after k-th edge, high when (k mod 8) >= 4
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            chk("R2 divider phase", slow_clk, ((k % 8) >= 4) ? 1 : 0);
        end

        // R3 R4 R6 R7 R8 table walk
        for (int n = 0; n < NVEC + 2; n++) begin
            @(negedge clk);
            if (n >= 2) chk("R6 table (R3/R4/R7/R8)", en_out, TABLE[n-2][4:0]);
            if (n < NVEC) begin
                mode_oneshot = TABLE[n][10];
                en_in        = TABLE[n][9:5];
            end else begin
                mode_oneshot = 1'b1;
                en_in        = '0;
            end
        end

        // R5 long hold: one pulse per lane
        repeat (3) @(negedge clk);
        for (int i = 0; i < NUM_CH; i++) cnt[i] = 0;
        en_in = '1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            for (int i = 0; i < NUM_CH; i++) cnt[i] += int'(en_out[i]);
        end
        for (int i = 0; i < NUM_CH; i++) chk("R5 pulses under long hold", cnt[i], 1);

        // R5 drop for one edge then re-assert gives a new pulse
        en_in = '0;
        @(negedge clk);
        en_in = '1;
        for (int i = 0; i < NUM_CH; i++) cnt[i] = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            for (int i = 0; i < NUM_CH; i++) cnt[i] += int'(en_out[i]);
        end
        for (int i = 0; i < NUM_CH; i++) chk("R5 pulse after one-cycle gap", cnt[i], 1);

        // R1 mid-run reset with pass-through and held input
        mode_oneshot = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 held pass-through", en_out, 5'b11111);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset edge", en_out, 0);
        chk("R1 slow clock after reset edge", slow_clk, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 first edge after reset", en_out, 0);
        @(negedge clk);
        chk("R4 R6 second edge after reset", en_out, 5'b11111);

        finish_run();
    end
endmodule